// File: doc/BRIEF.md
# Station Address and Group Matcher

This block sits on the receive path of a token-ring media access controller and decides whether a frame's addresses belong to this station. Address bytes arrive one per clock, most significant byte first. A start pulse opens each address pair. The destination address comes first and the source address follows it, both the same width. A select input, sampled at the start pulse, sets that width: 48-bit long form or 16-bit short form.

The destination address is accepted when any one of three tests passes:
- it equals the station's own long or short address, and it is an individual address;
- it belongs to the fixed group block: the address is all ones above its low nibble, and that nibble selects a set bit in a 16-bit fixed enable map;
- it belongs to the programmable group block: the bits above the low five equal a programmed prefix, and the low five bits select a set bit in a 32-bit programmable map.

The source address is compared for equality with the station's address of the same width. Each result is latched one cycle after the last byte of its field and holds until the next start pulse.

A byte-wide write port loads the station addresses, both group prefixes and both maps. Writes take effect only while the `run` input is low.

Top module: `addr_match_unit`

## Requirements
- R1: After reset all five outputs are 0, and address bytes are ignored until the first start pulse.
- R2: A write on the configuration port takes effect only while `run` is 0; with `run` at 1 the write leaves every register unchanged. Register bytes, each most significant byte first: 0-5 long station address, 6-7 short station address, 8-9 fixed map (byte 8 holds map bits 15:8), 10-15 long group prefix, 16-17 short group prefix, 18-21 programmable map (byte 18 holds bits 31:24).
- R3: In long form the first six bytes form the destination address. When it matches, `da_mine` is 1 from the cycle after the sixth byte is accepted, and `da_done` pulses for exactly that one cycle.
- R4: In short form the first two bytes form a 16-bit destination address and bytes three and four form the source address; both are compared against the short station address.
- R5: Bit 7 of the first destination byte is the individual/group bit. When it is 1, the exact compare against the station address gives no match.
- R6: The fixed group test passes when all address bits above bit 3 are 1 and bit n of the fixed map is set, where n is address bits 3:0. A pass sets both `da_mine` and `da_group`.
- R7: The programmable group test passes when the address bits above bit 4 equal the same bits of the group prefix and bit k of the programmable map is set, where k is address bits 4:0. A pass sets both `da_mine` and `da_group`.
- R8: `sa_mine` is 1 from the cycle after the last source byte when the source address equals the station address of the same width. `sa_done` pulses in that cycle.
- R9: A start pulse clears all flags in the next cycle. Bytes with `byte_vld` at 0, and bytes beyond the end of the source address, have no effect.
- R10: The long/short select is sampled only at the start pulse; changing it during the address bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = running, configuration writes blocked |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration byte index |
| cfg_wdata | input | 8 | Configuration write data |
| long_sel | input | 1 | 1 = 48-bit addresses, 0 = 16-bit, sampled at `sof` |
| sof | input | 1 | Start of address pair |
| byte_vld | input | 1 | `byte_in` carries an address byte |
| byte_in | input | 8 | Address byte, most significant first |
| da_mine | output | 1 | Destination address accepted |
| da_group | output | 1 | Destination accepted through a group map |
| sa_mine | output | 1 | Source address equals the station address |
| da_done | output | 1 | One-cycle pulse: destination result just latched |
| sa_done | output | 1 | One-cycle pulse: source result just latched |

## Verification
The hardest case to reach is a destination address that equals the station address bit for bit while its individual/group bit is set. A correct station address never has that bit set, so the stimulus first reprograms the station address with the bit on while the block is stopped, sends that exact address, and then restores the original value. Every address pair also toggles the long/short select after the start pulse. Some pairs carry an invalid-byte gap, and some have extra bytes after the source address, so the sampling, gap and saturation paths are exercised alongside the match logic.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;

    localparam int DEF_LONG_W  = 48;
    localparam int DEF_SHORT_W = 16;
    localparam int DEF_FIX_IDX = 4;
    localparam int DEF_GRP_IDX = 5;

    // destination evaluation for the byte currently being accepted
    typedef struct packed {
        logic ig;        // individual/group bit of the address
        logic exact;     // equals station address
        logic fix_hit;   // fixed group map hit
        logic prog_hit;  // programmable group map hit
    } da_eval_t;

    // latched result flags
    typedef struct packed {
        logic da_mine;
        logic da_group;
        logic sa_mine;
        logic da_done;
        logic sa_done;
    } flag_t;

endpackage

// File: rtl/am_cfg_regs.sv
module am_cfg_regs #(
    parameter int LONG_W    = addr_match_pkg::DEF_LONG_W,
    parameter int SHORT_W   = addr_match_pkg::DEF_SHORT_W,
    parameter int FIX_IDX_W = addr_match_pkg::DEF_FIX_IDX,
    parameter int GRP_IDX_W = addr_match_pkg::DEF_GRP_IDX,
    localparam int LONG_B   = LONG_W / 8,
    localparam int SHORT_B  = SHORT_W / 8,
    localparam int FMAP_W   = 1 << FIX_IDX_W,
    localparam int GMAP_W   = 1 << GRP_IDX_W,
    localparam int FMAP_B   = FMAP_W / 8,
    localparam int GMAP_B   = GMAP_W / 8,
    localparam int NREG     = 2 * LONG_B + 2 * SHORT_B + FMAP_B + GMAP_B,
    localparam int AW       = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [7:0]         wdata,
    output logic [LONG_W-1:0]  long_addr,
    output logic [SHORT_W-1:0] short_addr,
    output logic [FMAP_W-1:0]  fix_map,
    output logic [LONG_W-1:0]  grp_long,
    output logic [SHORT_W-1:0] grp_short,
    output logic [GMAP_W-1:0]  grp_map
);

    localparam int OFF_LA = 0;
    localparam int OFF_SA = OFF_LA + LONG_B;
    localparam int OFF_FM = OFF_SA + SHORT_B;
    localparam int OFF_GL = OFF_FM + FMAP_B;
    localparam int OFF_GS = OFF_GL + LONG_B;
    localparam int OFF_GM = OFF_GS + SHORT_B;

    logic [7:0] regs_d [NREG];
    logic [7:0] regs_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && !run && (int'(waddr) < NREG)) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    // byte fields, most significant byte at the lowest index
    for (genvar g = 0; g < LONG_B; g++) begin : g_long
        assign long_addr[LONG_W-1-8*g -: 8] = regs_q[OFF_LA + g];
        assign grp_long [LONG_W-1-8*g -: 8] = regs_q[OFF_GL + g];
    end
    for (genvar g = 0; g < SHORT_B; g++) begin : g_short
        assign short_addr[SHORT_W-1-8*g -: 8] = regs_q[OFF_SA + g];
        assign grp_short [SHORT_W-1-8*g -: 8] = regs_q[OFF_GS + g];
    end
    for (genvar g = 0; g < FMAP_B; g++) begin : g_fmap
        assign fix_map[FMAP_W-1-8*g -: 8] = regs_q[OFF_FM + g];
    end
    for (genvar g = 0; g < GMAP_B; g++) begin : g_gmap
        assign grp_map[GMAP_W-1-8*g -: 8] = regs_q[OFF_GM + g];
    end

    AST_RUN_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(long_addr) && $stable(short_addr) && $stable(fix_map) &&
                 $stable(grp_long) && $stable(grp_short) && $stable(grp_map))); // R2

endmodule

// File: rtl/am_collector.sv
module am_collector #(
    parameter int LONG_W  = addr_match_pkg::DEF_LONG_W,
    parameter int SHORT_W = addr_match_pkg::DEF_SHORT_W,
    localparam int LONG_B = LONG_W / 8,
    localparam int SHORT_B = SHORT_W / 8,
    localparam int CNT_W  = $clog2(2 * LONG_B + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              long_sel,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic [LONG_W-1:0] asm_addr,
    output logic              is_long,
    output logic              da_last,
    output logic              sa_last
);

    typedef struct packed {
        logic [LONG_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              lng;
    } col_t;

    col_t st_d, st_q;
    logic [CNT_W-1:0] da_end, sa_end, total;

    always_comb begin
        st_d     = st_q;
        da_last  = 1'b0;
        sa_last  = 1'b0;
        asm_addr = {st_q.sh[LONG_W-9:0], byte_in};
        da_end   = st_q.lng ? CNT_W'(LONG_B - 1)     : CNT_W'(SHORT_B - 1);
        sa_end   = st_q.lng ? CNT_W'(2 * LONG_B - 1) : CNT_W'(2 * SHORT_B - 1);
        total    = st_q.lng ? CNT_W'(2 * LONG_B)     : CNT_W'(2 * SHORT_B);
        if (sof) begin
            st_d.cnt = '0;
            st_d.lng = long_sel;
            st_d.sh  = '0;
        end else if (byte_vld && (st_q.cnt < total)) begin
            st_d.sh  = asm_addr;
            st_d.cnt = st_q.cnt + 1'b1;
            da_last  = (st_q.cnt == da_end);
            sa_last  = (st_q.cnt == sa_end);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.cnt <= CNT_W'(2 * LONG_B);
            st_q.lng <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_long = st_q.lng;

    AST_FIELD_ENDS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({da_last, sa_last})); // R9

endmodule

// File: rtl/am_da_eval.sv
module am_da_eval #(
    parameter int LONG_W    = addr_match_pkg::DEF_LONG_W,
    parameter int SHORT_W   = addr_match_pkg::DEF_SHORT_W,
    parameter int FIX_IDX_W = addr_match_pkg::DEF_FIX_IDX,
    parameter int GRP_IDX_W = addr_match_pkg::DEF_GRP_IDX,
    localparam int FMAP_W   = 1 << FIX_IDX_W,
    localparam int GMAP_W   = 1 << GRP_IDX_W
) (
    input  logic [LONG_W-1:0]      asm_addr,
    input  logic                   is_long,
    input  logic [LONG_W-1:0]      long_addr,
    input  logic [SHORT_W-1:0]     short_addr,
    input  logic [FMAP_W-1:0]      fix_map,
    input  logic [LONG_W-1:0]      grp_long,
    input  logic [SHORT_W-1:0]     grp_short,
    input  logic [GMAP_W-1:0]      grp_map,
    output addr_match_pkg::da_eval_t res
);

    logic l_exact, s_exact, l_fcand, s_fcand, l_pfx, s_pfx;
    logic fbit, gbit;

    always_comb begin
        l_exact = (asm_addr == long_addr);
        s_exact = (asm_addr[SHORT_W-1:0] == short_addr);
        l_fcand = &asm_addr[LONG_W-1:FIX_IDX_W];
        s_fcand = &asm_addr[SHORT_W-1:FIX_IDX_W];
        l_pfx   = (asm_addr[LONG_W-1:GRP_IDX_W] == grp_long[LONG_W-1:GRP_IDX_W]);
        s_pfx   = (asm_addr[SHORT_W-1:GRP_IDX_W] == grp_short[SHORT_W-1:GRP_IDX_W]);
        fbit    = fix_map[asm_addr[FIX_IDX_W-1:0]];
        gbit    = grp_map[asm_addr[GRP_IDX_W-1:0]];

        res.ig       = is_long ? asm_addr[LONG_W-1] : asm_addr[SHORT_W-1];
        res.exact    = is_long ? l_exact : s_exact;
        res.fix_hit  = (is_long ? l_fcand : s_fcand) && fbit;
        res.prog_hit = (is_long ? l_pfx : s_pfx) && gbit;
    end

endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit #(
    parameter int LONG_W    = addr_match_pkg::DEF_LONG_W,
    parameter int SHORT_W   = addr_match_pkg::DEF_SHORT_W,
    parameter int FIX_IDX_W = addr_match_pkg::DEF_FIX_IDX,
    parameter int GRP_IDX_W = addr_match_pkg::DEF_GRP_IDX,
    localparam int FMAP_W   = 1 << FIX_IDX_W,
    localparam int GMAP_W   = 1 << GRP_IDX_W,
    localparam int NREG     = 2 * (LONG_W / 8) + 2 * (SHORT_W / 8) + FMAP_W / 8 + GMAP_W / 8,
    localparam int CFG_AW   = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              long_sel,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic              da_mine,
    output logic              da_group,
    output logic              sa_mine,
    output logic              da_done,
    output logic              sa_done
);

    import addr_match_pkg::*;

    logic [LONG_W-1:0]  long_addr, grp_long, asm_addr;
    logic [SHORT_W-1:0] short_addr, grp_short;
    logic [FMAP_W-1:0]  fix_map;
    logic [GMAP_W-1:0]  grp_map;
    logic               is_long, da_last, sa_last;
    da_eval_t           ev;
    flag_t              fl_d, fl_q;

    am_cfg_regs #(
        .LONG_W(LONG_W), .SHORT_W(SHORT_W),
        .FIX_IDX_W(FIX_IDX_W), .GRP_IDX_W(GRP_IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .run(run), .we(cfg_we),
        .waddr(cfg_addr), .wdata(cfg_wdata),
        .long_addr(long_addr), .short_addr(short_addr), .fix_map(fix_map),
        .grp_long(grp_long), .grp_short(grp_short), .grp_map(grp_map)
    );

    am_collector #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_col (
        .clk(clk), .rst_n(rst_n), .sof(sof), .long_sel(long_sel),
        .byte_vld(byte_vld), .byte_in(byte_in), .asm_addr(asm_addr),
        .is_long(is_long), .da_last(da_last), .sa_last(sa_last)
    );

    am_da_eval #(
        .LONG_W(LONG_W), .SHORT_W(SHORT_W),
        .FIX_IDX_W(FIX_IDX_W), .GRP_IDX_W(GRP_IDX_W)
    ) u_eval (
        .asm_addr(asm_addr), .is_long(is_long), .long_addr(long_addr),
        .short_addr(short_addr), .fix_map(fix_map), .grp_long(grp_long),
        .grp_short(grp_short), .grp_map(grp_map), .res(ev)
    );

    always_comb begin
        fl_d         = fl_q;
        fl_d.da_done = 1'b0;
        fl_d.sa_done = 1'b0;
        if (sof) begin
            fl_d = '0;
        end else begin
            if (da_last) begin
                fl_d.da_mine  = (ev.exact && !ev.ig) || ev.fix_hit || ev.prog_hit;
                fl_d.da_group = ev.fix_hit || ev.prog_hit;
                fl_d.da_done  = 1'b1;
            end
            if (sa_last) begin
                fl_d.sa_mine = ev.exact;
                fl_d.sa_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign da_mine  = fl_q.da_mine;
    assign da_group = fl_q.da_group;
    assign sa_mine  = fl_q.sa_mine;
    assign da_done  = fl_q.da_done;
    assign sa_done  = fl_q.sa_done;

    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (!da_mine && !da_group && !sa_mine && !da_done && !sa_done)); // R9
    AST_DA_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        da_done |=> !da_done); // R3
    AST_DA_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(da_mine) |-> (da_done || $past(sof))); // R3
    AST_GROUP_IS_MINE: assert property (@(posedge clk) disable iff (!rst_n)
        da_group |-> da_mine); // R6
    AST_DONE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({da_done, sa_done})); // R8

endmodule

// File: tb/addr_match_unit_tb.sv
module addr_match_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       long_sel = 1'b1;
    logic       sof = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic       da_mine, da_group, sa_mine, da_done, sa_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    addr_match_unit u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .long_sel(long_sel), .sof(sof), .byte_vld(byte_vld),
        .byte_in(byte_in), .da_mine(da_mine), .da_group(da_group), .sa_mine(sa_mine),
        .da_done(da_done), .sa_done(sa_done)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_cfg [22];
    logic [7:0] m_bytes [$];
    bit   m_long;
    bit   e_da, e_grp, e_sa, e_dd, e_sd;

    function automatic logic [47:0] cfg_val(int base, int n);
        logic [47:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[39:0], m_cfg[base + i]};
        return v;
    endfunction

    function automatic logic [47:0] field_val(int first, int n);
        logic [47:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[39:0], m_bytes[first + i]};
        return v;
    endfunction

    task automatic model_da();
        int w = m_long ? 48 : 16;
        logic [47:0] a = field_val(0, w / 8);
        logic [47:0] own = m_long ? cfg_val(0, 6) : cfg_val(6, 2);
        logic [47:0] pfx = m_long ? cfg_val(10, 6) : cfg_val(16, 2);
        logic [15:0] fm = cfg_val(8, 2);
        logic [31:0] gm = cfg_val(18, 4);
        bit ones = 1, peq = 1, fix, prog;
        for (int b = 4; b < w; b++) if (!a[b]) ones = 0;
        for (int b = 5; b < w; b++) if (a[b] != pfx[b]) peq = 0;
        fix  = ones && fm[a[3:0]];
        prog = peq && gm[a[4:0]];
        e_grp = fix || prog;
        e_da  = e_grp || ((a == own) && !a[w-1]);
        e_dd  = 1;
    endtask

    task automatic model_sa();
        int n = m_long ? 6 : 2;
        logic [47:0] own = m_long ? cfg_val(0, 6) : cfg_val(6, 2);
        e_sa = (field_val(n, n) == own);
        e_sd = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 22; i++) m_cfg[i] = 8'h00;
            m_bytes.delete();
            for (int i = 0; i < 12; i++) m_bytes.push_back(8'h00);
            m_long = 1;
            {e_da, e_grp, e_sa, e_dd, e_sd} = '0;
        end else begin
            e_dd = 0;
            e_sd = 0;
            if (sof) begin
                m_bytes.delete();
                m_long = long_sel;
                {e_da, e_grp, e_sa} = '0;
            end else if (byte_vld && m_bytes.size() < (m_long ? 12 : 4)) begin
                m_bytes.push_back(byte_in);
                if (m_bytes.size() == (m_long ? 6 : 2)) model_da();
                if (m_bytes.size() == (m_long ? 12 : 4)) model_sa();
            end
            if (cfg_we && !run && cfg_addr < 22) m_cfg[cfg_addr] = cfg_wdata;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 da_mine vs model", da_mine, e_da);
            chk("R6 da_group vs model", da_group, e_grp);
            chk("R8 sa_mine vs model", sa_mine, e_sa);
            chk("R3 da_done vs model", da_done, e_dd);
            chk("R8 sa_done vs model", sa_done, e_sd);
        end
    end

    // ---------------- stimulus ----------------
    localparam logic [47:0] MLA = 48'h0A1B2C3D4E5F;
    localparam logic [175:0] CFG_IMG = {MLA, 16'h1234, 16'h8001,
                                        48'h812233445560, 16'h9A40, 32'h00000004};

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // bytes MSB first from v; optional invalid gap after byte 2; select flipped after sof (R10)
    task automatic send(bit lng, logic [95:0] v, int n, bit gap);
        @(negedge clk);
        sof = 1; long_sel = lng;
        @(negedge clk);
        sof = 0; long_sel = !lng;
        for (int k = 0; k < n; k++) begin
            if (gap && k == 2) begin
                byte_vld = 0; byte_in = 8'hFF;
                @(negedge clk);
            end
            byte_vld = 1; byte_in = v[95 - 8*k -: 8];
            @(negedge clk);
        end
        byte_vld = 0; byte_in = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset da_mine", da_mine, 0);
        chk("R1 reset sa_mine", sa_mine, 0);
        rst_n = 1;
        @(negedge clk);
        byte_vld = 1; byte_in = 8'h0A;
        repeat (14) @(negedge clk);
        byte_vld = 0;
        chk("R1 bytes ignored before first sof", da_done | da_mine, 0);

        for (int k = 0; k < 22; k++) wr(k, CFG_IMG[175 - 8*k -: 8]);
        run = 1;

        send(1, {MLA, MLA}, 12, 0);
        chk("R3 long own destination", da_mine, 1);
        chk("R8 long own source", sa_mine, 1);
        chk("R10 select change ignored", da_group, 0);
        send(1, {MLA, 48'h0A1B2C3D4E50}, 12, 1);
        chk("R8 source mismatch", sa_mine, 0);
        chk("R9 gap byte ignored", da_mine, 1);

        run = 0; wr(0, 8'h8A); run = 1;
        send(1, {48'h8A1B2C3D4E5F, MLA}, 12, 0);
        chk("R5 group bit blocks exact compare", da_mine, 0);
        run = 0; wr(0, 8'h0A); run = 1;

        send(1, {48'hFFFFFFFFFFF0, MLA}, 12, 0);
        chk("R6 fixed map bit 0", da_mine, 1);
        chk("R6 fixed group flag", da_group, 1);
        send(1, {48'hFFFFFFFFFFF5, MLA}, 12, 0);
        chk("R6 fixed map bit 5 clear", da_mine, 0);
        send(1, {48'hFFFFFFFFFFFF, MLA}, 12, 0);
        chk("R6 fixed map bit 15", da_group, 1);
        send(1, {48'h812233445562, MLA}, 12, 0);
        chk("R7 programmable map bit 2", da_group, 1);
        send(1, {48'h812233445563, MLA}, 12, 0);
        chk("R7 programmable map bit 3 clear", da_mine, 0);

        send(0, {32'h12341234, 64'h0}, 4, 0);
        chk("R4 short own destination", da_mine, 1);
        chk("R4 short own source", sa_mine, 1);
        send(0, {32'hFFF01234, 64'h0}, 4, 1);
        chk("R6 short fixed group", da_group, 1);
        send(0, {32'hFFF31234, 64'h0}, 4, 0);
        chk("R6 short fixed bit 3 clear", da_mine, 0);
        send(0, {32'h9A420000, 64'h0}, 4, 0);
        chk("R7 short programmable group", da_mine, 1);
        chk("R4 short source mismatch", sa_mine, 0);

        wr(5, 8'h00); wr(7, 8'h00);
        send(1, {MLA, MLA}, 12, 0);
        chk("R2 write during run ignored (long)", da_mine, 1);
        send(0, {32'h12341234, 64'h0}, 4, 0);
        chk("R2 write during run ignored (short)", sa_mine, 1);

        @(negedge clk);
        byte_vld = 1; byte_in = 8'h00;
        repeat (3) @(negedge clk);
        byte_vld = 0;
        chk("R9 bytes past source ignored", sa_mine, 1);
        sof = 1;
        @(negedge clk);
        sof = 0;
        chk("R9 sof clears destination flag", da_mine, 0);
        chk("R9 sof clears source flag", sa_mine, 0);
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule